// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a simple synchronous host port and an external asynchronous static RAM of 64K words by 16 bits. The host gives one read or write request at a time. Each request carries a 16-bit word address, write data and a two-bit lane mask. The controller turns it into the active-low strobe sequence the memory expects. It drives chip select, write enable, output enable and one enable for each byte lane, and it manages a data bus split into an output value, an output-enable and an input value.

Every memory timing window is a count of system clock cycles set by a parameter: the read access time, the bus turnaround before the controller drives data, the data setup before the end of write, and the minimum write pulse. Output enable stays high for the whole of a write. Chip select, the lane enables and write enable fall together, and the data drivers turn on only after the turnaround count. This gives the memory's own drivers time to release. A request whose lane mask is empty completes at once and never selects the memory.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, chip select, write enable, output enable and both lane enables are high, the data drivers are off, ready is high, done is low and read data is zero.
- R2: A read holds chip select and output enable low and write enable high for exactly T_RD cycles, with the address steady. The low-lane enable (data bits 7:0) is low when mask bit 0 is set, and the high-lane enable (bits 15:8) is low when mask bit 1 is set.
- R3: Read data is captured at the end of the last access cycle. Each enabled lane takes the memory's input bits, and each disabled lane reads as zero.
- R4: A write holds output enable high throughout. It holds chip select, write enable and the enables selected by the mask low together for T_TURN + DPH cycles, where DPH = max(T_DSU, T_WP - T_TURN).
- R5: During a write, the data drivers are off for the first T_TURN write-enable-low cycles and on, carrying the request's write data, for the last DPH cycles. They are never on while output enable is low.
- R6: Write enable stays low for at least T_WP cycles, and the data is driven for at least T_DSU cycles before write enable rises.
- R7: Ready is low from the cycle after a request is accepted until completion. Done is high for exactly one cycle after each completed request, and ready is high in that cycle.
- R8: A request with an all-zero mask raises done in the next cycle and never pulls chip select low.
- R9: A request presented while ready is low is ignored. It starts no access and changes no memory word.
- R10: Chip select is high for at least one cycle between two consecutive accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken while ready_o is high |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Word address |
| wdata_i | input | 16 | Write data |
| bmask_i | input | 2 | Lane mask: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ready_o | output | 1 | Controller idle, request can be taken |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Captured read data |
| mem_addr_o | output | 16 | Memory address bus |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_hi_en_n_o | output | 1 | High-lane enable, active low |
| mem_lo_en_n_o | output | 1 | Low-lane enable, active low |
| mem_dq_o | output | 16 | Data to memory |
| mem_dq_oe_o | output | 1 | Data driver enable |
| mem_dq_i | input | 16 | Data from memory |

## Verification
The hardest case to reach is a request arriving while an access is in flight, together with back-to-back accesses that change direction. Here the bus turnaround and the idle gap between selections matter. The stimulus issues each new request in the very cycle done is seen, and it keeps the request line high with different address and data for the whole of some accesses. It then reads back the address those ignored requests named. A bench memory model serves reads only with the enables the controller actually drives, and it stores writes only while the strobes overlap with the drivers on. It also places a fixed junk pattern on disabled lanes, so lane steering faults show up in the read data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RD    = 2'd1,
    ST_WTURN = 2'd2,
    ST_WDATA = 2'd3
  } seq_st_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0]   mask_i,
  input  logic               act_i,
  input  logic [8*LANES-1:0] dq_i,
  output logic [LANES-1:0]   be_n_o,
  output logic [8*LANES-1:0] rd_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign be_n_o[l]        = ~(act_i & mask_i[l]);
    assign rd_o[8*l +: 8]   = mask_i[l] ? dq_i[8*l +: 8] : 8'h00;
  end
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int T_RD   = 3,
  parameter int T_TURN = 2,
  parameter int T_DPH  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic wr_i,
  input  logic mask_zero_i,
  output logic ready_o,
  output logic done_o,
  output logic accept_o,
  output logic cap_o,
  output logic cs_act_o,
  output logic we_act_o,
  output logic oe_act_o,
  output logic drive_o
);
  localparam int MAXC = max2(max2(T_RD, T_TURN), T_DPH);
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] RD_LAST   = CW'(T_RD - 1);
  localparam logic [CW-1:0] TURN_LAST = CW'((T_TURN == 0) ? 0 : T_TURN - 1);
  localparam logic [CW-1:0] DPH_LAST  = CW'(T_DPH - 1);

  seq_st_e st_q;
  logic [CW-1:0] cnt_q;
  logic done_q;

  assign ready_o  = (st_q == ST_IDLE);
  assign accept_o = ready_o & req_i & ~mask_zero_i;
  assign cap_o    = (st_q == ST_RD) && (cnt_q == RD_LAST);
  assign cs_act_o = (st_q != ST_IDLE);
  assign we_act_o = (st_q == ST_WTURN) || (st_q == ST_WDATA);
  assign oe_act_o = (st_q == ST_RD);
  assign drive_o  = (st_q == ST_WDATA);
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (req_i) begin
            if (mask_zero_i)   done_q <= 1'b1;
            else if (!wr_i)    st_q   <= ST_RD;
            else if (T_TURN == 0) st_q <= ST_WDATA;
            else               st_q   <= ST_WTURN;
          end
        end
        ST_RD: begin
          if (cnt_q == RD_LAST) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            done_q <= 1'b1;
          end else cnt_q <= cnt_q + CW'(1);
        end
        ST_WTURN: begin
          if (cnt_q == TURN_LAST) begin
            st_q  <= ST_WDATA;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + CW'(1);
        end
        ST_WDATA: begin
          if (cnt_q == DPH_LAST) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            done_q <= 1'b1;
          end else cnt_q <= cnt_q + CW'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int T_RD   = 3,
  parameter int T_TURN = 2,
  parameter int T_DSU  = 2,
  parameter int T_WP   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        bmask_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_n_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_hi_en_n_o,
  output logic              mem_lo_en_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int LANES = DATA_W / 8;
  // data phase long enough for setup and for the minimum pulse
  localparam int T_DPH = max2(T_DSU, T_WP - T_TURN);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, rd_merge;
  logic [LANES-1:0]  mask_q, be_n;
  logic accept, cap, cs_act, we_act, oe_act, drive;

  sram_seq #(.T_RD(T_RD), .T_TURN(T_TURN), .T_DPH(T_DPH)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .wr_i        (wr_i),
    .mask_zero_i (bmask_i == 2'b00),
    .ready_o     (ready_o),
    .done_o      (done_o),
    .accept_o    (accept),
    .cap_o       (cap),
    .cs_act_o    (cs_act),
    .we_act_o    (we_act),
    .oe_act_o    (oe_act),
    .drive_o     (drive)
  );

  sram_lane_map #(.LANES(LANES)) u_lane (
    .mask_i (mask_q),
    .act_i  (cs_act),
    .dq_i   (mem_dq_i),
    .be_n_o (be_n),
    .rd_o   (rd_merge)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        mask_q  <= LANES'(bmask_i);
      end
      if (cap) rdata_q <= rd_merge;
    end
  end

  assign rdata_o       = rdata_q;
  assign mem_addr_o    = addr_q;
  assign mem_cs_n_o    = ~cs_act;
  assign mem_we_n_o    = ~we_act;
  assign mem_oe_n_o    = ~oe_act;
  assign mem_lo_en_n_o = be_n[0];
  assign mem_hi_en_n_o = be_n[LANES-1];
  assign mem_dq_o      = wdata_q;
  assign mem_dq_oe_o   = drive;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int T_WP  = 2,
  parameter int T_DSU = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ready_o,
  input logic done_o,
  input logic mem_cs_n_o,
  input logic mem_we_n_o,
  input logic mem_oe_n_o,
  input logic mem_hi_en_n_o,
  input logic mem_lo_en_n_o,
  input logic mem_dq_oe_o
);
  int we_lo_cnt, dq_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_lo_cnt <= 0;
      dq_cnt    <= 0;
    end else begin
      we_lo_cnt <= mem_we_n_o  ? 0 : we_lo_cnt + 1;
      dq_cnt    <= mem_dq_oe_o ? dq_cnt + 1 : 0;
    end
  end

  // R4
  wr_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (mem_oe_n_o && !mem_cs_n_o && !(mem_hi_en_n_o && mem_lo_en_n_o)));

  // R5
  dq_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (!mem_we_n_o && mem_oe_n_o));

  // R2
  rd_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> (mem_we_n_o && !mem_cs_n_o && !mem_dq_oe_o));

  // R6
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (we_lo_cnt >= T_WP && $past(mem_dq_oe_o)));

  // R6
  wr_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_dq_oe_o) |-> (dq_cnt >= T_DSU));

  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ready_o && mem_cs_n_o));

  // R10
  idle_desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> mem_cs_n_o);
endmodule

bind sram_ctrl sram_ctrl_chk #(.T_WP(T_WP), .T_DSU(T_DSU)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ready_o       (ready_o),
  .done_o        (done_o),
  .mem_cs_n_o    (mem_cs_n_o),
  .mem_we_n_o    (mem_we_n_o),
  .mem_oe_n_o    (mem_oe_n_o),
  .mem_hi_en_n_o (mem_hi_en_n_o),
  .mem_lo_en_n_o (mem_lo_en_n_o),
  .mem_dq_oe_o   (mem_dq_oe_o)
);

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;
  localparam int T_RD = 3, T_TURN = 2, T_DSU = 2, T_WP = 2;
  localparam int DPH  = (T_DSU > T_WP - T_TURN) ? T_DSU : T_WP - T_TURN;
  localparam int WE_LEN = T_TURN + DPH;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_i = 0, wr_i = 0;
  logic [15:0] addr_i = '0, wdata_i = '0;
  logic [1:0]  bmask_i = '0;
  logic ready_o, done_o, mem_cs_n_o, mem_we_n_o, mem_oe_n_o;
  logic mem_hi_en_n_o, mem_lo_en_n_o, mem_dq_oe_o;
  logic [15:0] rdata_o, mem_addr_o, mem_dq_o, mem_dq_i;

  int n_chk = 0, n_fail = 0;
  logic [15:0] sram_m [int];
  logic [15:0] ref_m  [int];

  always #2 clk = ~clk;

  sram_ctrl #(.T_RD(T_RD), .T_TURN(T_TURN), .T_DSU(T_DSU), .T_WP(T_WP)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .bmask_i(bmask_i), .ready_o(ready_o), .done_o(done_o),
    .rdata_o(rdata_o), .mem_addr_o(mem_addr_o), .mem_cs_n_o(mem_cs_n_o),
    .mem_we_n_o(mem_we_n_o), .mem_oe_n_o(mem_oe_n_o), .mem_hi_en_n_o(mem_hi_en_n_o),
    .mem_lo_en_n_o(mem_lo_en_n_o), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe_o),
    .mem_dq_i(mem_dq_i)
  );

  function automatic logic [15:0] sram_get(input int a);
    return sram_m.exists(a) ? sram_m[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] ref_get(input int a);
    return ref_m.exists(a) ? ref_m[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] lane_merge(input logic [15:0] old, input logic [15:0] d,
                                             input logic [1:0] m);
    return {m[1] ? d[15:8] : old[15:8], m[0] ? d[7:0] : old[7:0]};
  endfunction
  function automatic logic [15:0] rd_expect(input logic [15:0] v, input logic [1:0] m);
    return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
  endfunction

  // memory model: serves only enabled lanes, junk elsewhere
  always @(*) begin
    logic [15:0] v;
    v = sram_get(int'(mem_addr_o));
    mem_dq_i = 16'hC3C3;
    if (!mem_cs_n_o && !mem_oe_n_o && mem_we_n_o) begin
      if (!mem_lo_en_n_o) mem_dq_i[7:0]  = v[7:0];
      if (!mem_hi_en_n_o) mem_dq_i[15:8] = v[15:8];
    end
  end

  always @(posedge clk) begin
    logic [15:0] v;
    if (!mem_cs_n_o && !mem_we_n_o && mem_dq_oe_o) begin
      v = sram_get(int'(mem_addr_o));
      if (!mem_lo_en_n_o) v[7:0]  = mem_dq_o[7:0];
      if (!mem_hi_en_n_o) v[15:8] = mem_dq_o[15:8];
      sram_m[int'(mem_addr_o)] = v;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input bit wr, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] m, input bit poke);
    int cyc = 0, cs_lo = 0, we_lo = 0, oe_lo = 0, dq_on = 0, first_dq = 0;
    int be_bad = 0, dq_bad = 0, rdy_bad = 0, addr_bad = 0;
    chk(ready_o && mem_cs_n_o, "R10 deselected before access", {ready_o, mem_cs_n_o}, 2'b11);
    req_i = 1; wr_i = wr; addr_i = a; wdata_i = d; bmask_i = m;
    @(posedge clk); @(negedge clk);
    if (poke) begin
      addr_i = a ^ 16'h0005; wdata_i = ~d; bmask_i = 2'b11; wr_i = 1'b1;
    end else req_i = 0;
    while (!done_o && cyc < 64) begin
      if (!mem_cs_n_o) cs_lo++;
      if (!mem_oe_n_o) oe_lo++;
      if (!mem_we_n_o) we_lo++;
      if (mem_dq_oe_o) begin
        dq_on++;
        if (first_dq == 0) first_dq = we_lo;
        if (mem_dq_o != d) dq_bad++;
      end
      if (!mem_cs_n_o && ({mem_hi_en_n_o, mem_lo_en_n_o} != ~m)) be_bad++;
      if (!mem_cs_n_o && mem_addr_o != a) addr_bad++;
      if (ready_o) rdy_bad++;
      cyc++;
      @(negedge clk);
    end
    req_i = 0;
    chk(done_o, "R7 done reached", done_o, 1);
    chk(rdy_bad == 0, "R7 ready low while busy", rdy_bad, 0);
    if (m == 2'b00) begin
      chk(cyc == 0, "R8 immediate completion", cyc, 0);
      chk(cs_lo == 0, "R8 no chip select", cs_lo, 0);
    end else if (!wr) begin
      chk(cs_lo == T_RD && oe_lo == T_RD && we_lo == 0, "R2 read strobe cycles",
          {cs_lo[7:0], oe_lo[7:0], we_lo[7:0]}, {T_RD[7:0], T_RD[7:0], 8'h00});
      chk(be_bad == 0 && addr_bad == 0, "R2 lane enables and address", {be_bad[15:0], addr_bad[15:0]}, 0);
      chk(rdata_o == rd_expect(ref_get(int'(a)), m), "R3 read data", rdata_o,
          rd_expect(ref_get(int'(a)), m));
    end else begin
      chk(we_lo == WE_LEN && cs_lo == WE_LEN, "R4 write pulse length", {cs_lo[15:0], we_lo[15:0]},
          {WE_LEN[15:0], WE_LEN[15:0]});
      chk(oe_lo == 0, "R4 output enable high in write", oe_lo, 0);
      chk(be_bad == 0 && addr_bad == 0, "R4 lane enables and address", {be_bad[15:0], addr_bad[15:0]}, 0);
      chk(first_dq == T_TURN + 1 && dq_on == DPH, "R5 turnaround then drive",
          {first_dq[15:0], dq_on[15:0]}, {16'(T_TURN + 1), DPH[15:0]});
      chk(dq_bad == 0, "R5 write data value", dq_bad, 0);
      chk(we_lo >= T_WP && dq_on >= T_DSU, "R6 pulse and setup minimum", {we_lo[15:0], dq_on[15:0]},
          {T_WP[15:0], T_DSU[15:0]});
      ref_m[int'(a)] = lane_merge(ref_get(int'(a)), d, m);
    end
  endtask

  task automatic idle_chk();
    @(negedge clk);
    chk(!done_o && mem_cs_n_o && ready_o, "R7 done single cycle",
        {done_o, mem_cs_n_o, ready_o}, 3'b011);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({mem_cs_n_o, mem_we_n_o, mem_oe_n_o, mem_hi_en_n_o, mem_lo_en_n_o, mem_dq_oe_o,
         ready_o, done_o} == 8'b11111010 && rdata_o == 16'h0, "R1 reset state",
        {mem_cs_n_o, mem_we_n_o, mem_oe_n_o, mem_hi_en_n_o, mem_lo_en_n_o, mem_dq_oe_o,
         ready_o, done_o}, 8'b11111010);
    rst_ni = 1;
    @(negedge clk);

    do_op(1, 16'h0000, 16'hBEEF, 2'b11, 0);
    idle_chk();
    do_op(0, 16'h0000, 16'h0000, 2'b11, 0);
    do_op(1, 16'hFFFF, 16'h1234, 2'b01, 0);   // low lane only, back to back
    do_op(0, 16'hFFFF, 16'h0000, 2'b10, 0);   // high lane read sees zero
    do_op(0, 16'hFFFF, 16'h0000, 2'b01, 0);
    do_op(1, 16'hFFFF, 16'hAB00, 2'b10, 0);
    do_op(0, 16'hFFFF, 16'h0000, 2'b11, 0);
    do_op(1, 16'h0000, 16'h7777, 2'b00, 0);   // R8 zero mask write
    do_op(0, 16'h0000, 16'h0000, 2'b00, 0);   // R8 zero mask read
    idle_chk();
    do_op(0, 16'h0000, 16'h0000, 2'b11, 0);   // R8 nothing written
    // R9 request held high during busy
    do_op(1, 16'h0010, 16'h5A5A, 2'b11, 1);
    idle_chk();
    do_op(0, 16'h0015, 16'h0000, 2'b11, 0);   // R9 poked address untouched
    do_op(0, 16'h0010, 16'h0000, 2'b11, 1);
    idle_chk();
    do_op(0, 16'h0015, 16'h0000, 2'b11, 0);

    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      a = ($urandom_range(0, 9) == 0) ? 16'hFFFF : 16'($urandom_range(0, 15));
      do_op(1'($urandom_range(0, 1)), a, 16'($urandom), 2'($urandom_range(0, 3)),
            $urandom_range(0, 7) == 0);
      if ($urandom_range(0, 3) == 0) idle_chk();
    end
    idle_chk();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule